// File: doc/BRIEF.md
# Dual-Pulse Presettable Up/Down Counter

This block is one digit of a counter that moves on two separate pulse lines: a rising edge on the up line adds one and a rising edge on the down line subtracts one. A parameter picks the digit's range, either a decimal digit (0 to 9) or a full 4-bit nibble (0 to 15). A clear input forces the digit to zero. A parallel load input copies a preset value into the digit. Both of these take priority over any counting.

Each stage has two active-low terminal outputs, carry and borrow. They go low only while the digit is at its end of range and the matching pulse line is low. They return high at the moment that pulse line rises. This lets them serve directly as the up and down pulse lines of the next stage, so several stages chain into a multi-digit counter with no glue logic.

The pulse lines are not used as clocks. One system clock samples both lines, and the digit changes on the first system edge that finds a line high after it was sampled low. The carry and borrow outputs are combinational from the digit and the raw pulse levels. A rising pulse edge therefore reaches every stage of a chain during the same system cycle.

Top module: `dual_pulse_counter`

## Requirements
- R1: When the up line is sampled high by the system clock after being sampled low, and the down line shows no such edge at that clock, the count increases by one at that system clock edge.
- R2: When the down line shows a rising edge at a system clock edge and the up line shows none, the count decreases by one at that edge.
- R3: With DECADE=1 the count wraps from 9 to 0 when counting up and from 0 to 9 when counting down.
- R4: With DECADE=0 the count wraps from 15 to 0 when counting up and from 0 to 15 when counting down.
- R5: carry_n is 0 exactly while the count equals the top value (9 when DECADE=1, 15 when DECADE=0) and the up line is low. Otherwise it is 1.
- R6: borrow_n is 0 exactly while the count is 0 and the down line is low. Otherwise it is 1.
- R7: While clear is 1, the count becomes 0 at the next system clock edge, whatever load_n and the pulse lines do.
- R8: While clear is 0 and load_n is 0, the count takes the value of preset at the next system clock edge, and pulse edges are ignored.
- R9: If both pulse lines show a rising edge at the same system clock edge, the count does not change.
- R10: With DECADE=1, a loaded value from 10 to 15 steps by +1 or -1 modulo 16 (15 goes up to 0). Neither carry_n nor borrow_n goes low while the count is in that range.
- R11: When a stage's carry_n drives the next stage's up line and its borrow_n drives the next stage's down line, the chain counts as a multi-digit number. Both stages update at the same system edge.
- R12: While rst_n is 0 the count is 0. A pulse line that is already high when rst_n is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the pulse lines |
| rst_n | input | 1 | Active-low asynchronous system reset |
| clear | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load |
| preset | input | W | Value copied into the count on a load |
| cnt_up | input | 1 | Count-up pulse line (acts on its rising edge) |
| cnt_dn | input | 1 | Count-down pulse line (acts on its rising edge) |
| count | output | W | Present count |
| carry_n | output | 1 | Active-low terminal-count-up output |
| borrow_n | output | 1 | Active-low terminal-count-down output |

## Verification
Clear and load can land on the same system edge as a pulse edge. To provoke this, the bench raises a pulse line while clear, or load, is already held active. It then judges the result by finding the clear value or the preset value in the count, rather than the stepped value. Rising edges on the up and down lines can also coincide. The bench raises both lines between the same pair of system edges and expects the count to stay where it was. Finally, in a two-stage chain, the lower stage's wrap and the upper stage's step must fall in the same cycle. The bench checks the combined value after each pulse of complete up and down sweeps.

// File: rtl/dual_pulse_counter_pkg.sv
package dual_pulse_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_UP    = 2'd1,
    OP_DOWN  = 2'd2
  } step_op_t;
endpackage

// File: rtl/pulse_edge.sv
module pulse_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  logic seen_q;

  // Held high in reset so that a line already high at release is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b1;
    else        seen_q <= line_i;
  end

  assign rise_o = line_i & ~seen_q;
endmodule

// File: rtl/count_core.sv
module count_core
  import dual_pulse_counter_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  step_op_t     op,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP  = DECADE ? W'(9) : {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] value_q, inc_v, dec_v;

  generate
    if (DECADE) begin : g_dec
      assign inc_v = (value_q == TOP) ? ZERO : value_q + ONE;
      assign dec_v = (value_q == ZERO) ? TOP : value_q - ONE;
    end else begin : g_bin
      assign inc_v = value_q + ONE;
      assign dec_v = value_q - ONE;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= ZERO;
    else if (clear)   value_q <= ZERO;
    else if (!load_n) value_q <= preset;
    else begin
      unique case (op)
        OP_UP:   value_q <= inc_v;
        OP_DOWN: value_q <= dec_v;
        default: value_q <= value_q;
      endcase
    end
  end

  assign value = value_q;
endmodule

// File: rtl/term_detect.sv
module term_detect #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic [W-1:0] value,
  input  logic         up_line,
  input  logic         dn_line,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  assign carry_n  = ~((value == TOP) & ~up_line);
  assign borrow_n = ~((value == '0) & ~dn_line);
endmodule

// File: rtl/dual_pulse_counter.sv
module dual_pulse_counter
  import dual_pulse_counter_pkg::*;
#(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         cnt_up,
  input  logic         cnt_dn,
  output logic [W-1:0] count,
  output logic         carry_n,
  output logic         borrow_n
);
  logic     up_rise, dn_rise;
  step_op_t op;

  pulse_edge u_up_edge (.clk(clk), .rst_n(rst_n), .line_i(cnt_up), .rise_o(up_rise));
  pulse_edge u_dn_edge (.clk(clk), .rst_n(rst_n), .line_i(cnt_dn), .rise_o(dn_rise));

  always_comb begin
    unique case ({up_rise, dn_rise})
      2'b10:   op = OP_UP;
      2'b01:   op = OP_DOWN;
      default: op = OP_HOLD;
    endcase
  end

  count_core #(.W(W), .DECADE(DECADE)) u_core (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n),
    .preset(preset), .op(op), .value(count)
  );

  term_detect #(.W(W), .DECADE(DECADE)) u_term (
    .value(count), .up_line(cnt_up), .dn_line(cnt_dn),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/dual_pulse_counter_chk.sv
module dual_pulse_counter_chk #(
  parameter int W      = 4,
  parameter bit DECADE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear,
  input logic         load_n,
  input logic [W-1:0] preset,
  input logic         cnt_up,
  input logic         cnt_dn,
  input logic [W-1:0] count,
  input logic         carry_n,
  input logic         borrow_n
);
  localparam logic [W-1:0] TOP = DECADE ? W'(9) : {W{1'b1}};

  function automatic logic [W-1:0] nxt_up(input logic [W-1:0] v);
    return (DECADE && v == TOP) ? '0 : v + W'(1);
  endfunction

  function automatic logic [W-1:0] nxt_dn(input logic [W-1:0] v);
    return (v == '0) ? TOP : v - W'(1);
  endfunction

  // R1
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !clear && load_n && $rose(cnt_up) && !$rose(cnt_dn))
    |=> count == nxt_up($past(count)));

  // R2
  count_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !clear && load_n && $rose(cnt_dn) && !$rose(cnt_up))
    |=> count == nxt_dn($past(count)));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> count == $past(preset));

  // R9
  both_edges_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !clear && load_n && $rose(cnt_up) && $rose(cnt_dn))
    |=> $stable(count));

  // R10
  no_term_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count > TOP) |-> (carry_n && borrow_n));
endmodule

bind dual_pulse_counter dual_pulse_counter_chk #(.W(W), .DECADE(DECADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .load_n(load_n), .preset(preset),
  .cnt_up(cnt_up), .cnt_dn(cnt_dn), .count(count),
  .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/dual_pulse_counter_test.sv
module dual_pulse_counter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ld_n = 1'b1, up = 1'b1, dn = 1'b1;
  logic [3:0] dp_lo = '0, dp_hi = '0, bp_lo = '0, bp_hi = '0;
  logic [3:0] dq_lo, dq_hi, bq_lo, bq_hi;
  logic dc_lo, dc_hi, db_lo, db_hi, bc_lo, bc_hi, bb_lo, bb_hi;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_pulse_counter #(.W(4), .DECADE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clr), .load_n(ld_n), .preset(dp_lo),
    .cnt_up(up), .cnt_dn(dn), .count(dq_lo), .carry_n(dc_lo), .borrow_n(db_lo));
  dual_pulse_counter #(.W(4), .DECADE(1'b1)) uut_hi (
    .clk(clk), .rst_n(rst_n), .clear(clr), .load_n(ld_n), .preset(dp_hi),
    .cnt_up(dc_lo), .cnt_dn(db_lo), .count(dq_hi), .carry_n(dc_hi), .borrow_n(db_hi));
  dual_pulse_counter #(.W(4), .DECADE(1'b0)) bin_lo (
    .clk(clk), .rst_n(rst_n), .clear(clr), .load_n(ld_n), .preset(bp_lo),
    .cnt_up(up), .cnt_dn(dn), .count(bq_lo), .carry_n(bc_lo), .borrow_n(bb_lo));
  dual_pulse_counter #(.W(4), .DECADE(1'b0)) bin_hi (
    .clk(clk), .rst_n(rst_n), .clear(clr), .load_n(ld_n), .preset(bp_hi),
    .cnt_up(bc_lo), .cnt_dn(bb_lo), .count(bq_hi), .carry_n(bc_hi), .borrow_n(bb_hi));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One pulse on up (is_up) or down, chain value v before the pulse.
  task automatic pulse(input bit is_up, input int v);
    int dv, bv, nv;
    dv = ((v % 100) + 100) % 100;
    bv = ((v % 256) + 256) % 256;
    @(negedge clk);
    if (is_up) up = 1'b0; else dn = 1'b0;
    @(negedge clk);
    if (is_up) begin
      chk("R5 decade carry phase", dc_lo, (dv % 10 == 9) ? 0 : 1);
      chk("R5 binary carry phase", bc_lo, (bv % 16 == 15) ? 0 : 1);
      chk("R6 borrow idle", db_lo, 1);
    end else begin
      chk("R6 decade borrow phase", db_lo, (dv % 10 == 0) ? 0 : 1);
      chk("R6 binary borrow phase", bb_lo, (bv % 16 == 0) ? 0 : 1);
      chk("R5 carry idle", dc_lo, 1);
    end
    up = 1'b1; dn = 1'b1;
    @(negedge clk);
    chk("R5 R6 terminals released", {dc_lo, db_lo, bc_lo, bb_lo}, 4'hF);
    nv = is_up ? v + 1 : v - 1;
    chk(is_up ? "R1/R3/R11 decade chain" : "R2/R3/R11 decade chain",
        dq_hi * 10 + dq_lo, ((nv % 100) + 100) % 100);
    chk(is_up ? "R1/R4/R11 binary chain" : "R2/R4/R11 binary chain",
        {bq_hi, bq_lo}, ((nv % 256) + 256) % 256);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_load(input logic [3:0] lo, input logic [3:0] hi);
    @(negedge clk); dp_lo = lo; dp_hi = hi; ld_n = 1'b0;
    @(negedge clk); ld_n = 1'b1;
  endtask

  initial begin
    // R12: line rises while reset is held; release must not count it
    up = 1'b0;
    repeat (2) @(negedge clk);
    up = 1'b1;
    @(negedge clk);
    chk("R12 reset count", {dq_hi, dq_lo, bq_hi, bq_lo}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 no edge at release", {dq_hi, dq_lo, bq_hi, bq_lo}, 0);

    for (int k = 0; k < 256; k++) pulse(1'b1, k);
    do_clear();
    chk("R7 clear after sweep", {dq_hi, dq_lo, bq_hi, bq_lo}, 0);
    for (int k = 0; k < 256; k++) pulse(1'b0, -k);

    // R7: clear held while up rises and load is also active
    do_clear();
    @(negedge clk); up = 1'b0; clr = 1'b1; ld_n = 1'b0; dp_lo = 4'd5; bp_lo = 4'd5;
    @(negedge clk); up = 1'b1;
    @(negedge clk);
    chk("R7 clear over pulse and load", {dq_lo, bq_lo}, 0);
    clr = 1'b0; ld_n = 1'b1;

    // R8: load held while up and down rise
    @(negedge clk); up = 1'b0; ld_n = 1'b0; dp_lo = 4'd7; dp_hi = 4'd2;
    @(negedge clk); up = 1'b1;
    @(negedge clk);
    chk("R8 load over up pulse", dq_hi * 10 + dq_lo, 27);
    dn = 1'b0;
    @(negedge clk); dn = 1'b1;
    @(negedge clk);
    chk("R8 load over down pulse", dq_hi * 10 + dq_lo, 27);
    ld_n = 1'b1;

    // R9: coincident rises hold the count
    @(negedge clk); up = 1'b0; dn = 1'b0;
    @(negedge clk); up = 1'b1; dn = 1'b1;
    @(negedge clk);
    chk("R9 simultaneous edges", dq_hi * 10 + dq_lo, 27);

    // R10: invalid decade values step modulo 16 with no terminal pulse
    do_load(4'd12, 4'd3);
    for (int s = 13; s <= 16; s++) begin
      @(negedge clk); up = 1'b0;
      @(negedge clk);
      chk("R10 no carry from invalid", dc_lo, 1);
      up = 1'b1;
      @(negedge clk);
      chk("R10 invalid step up", dq_lo, s % 16);
      chk("R10 upper stage untouched", dq_hi, 3);
    end
    do_load(4'd10, 4'd3);
    @(negedge clk); dn = 1'b0;
    @(negedge clk);
    chk("R10 no borrow from invalid", db_lo, 1);
    dn = 1'b1;
    @(negedge clk);
    chk("R10 invalid step down", dq_hi * 10 + dq_lo, 39);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule